// File: doc/BRIEF.md
# Inverter Gate Protection Sequencer

This block sits between the six active-high switch commands of a three-phase inverter and the six gate-enable outputs. Each phase has a high-side and a low-side command. The block forces gates off when protection trips, and it raises an active-low fault line for events on the low side. Four digitized supply codes come in: one for the shared low-side gate supply and one for each phase's high-side floating supply. Each code is compared against its own trip and release thresholds, with hysteresis, in a small two-state supply watcher (`SUP_LOW`, `SUP_GOOD`). A separate flag comes from an external low-side short-circuit comparator.

A three-state fault sequencer (`FLT_IDLE`, `FLT_HOLD`, `FLT_EXTEND`) produces the fault pulse. `FLT_IDLE` moves to `FLT_HOLD` on a synchronized short-circuit sample or on a low-side undervoltage, and loads a cycle counter. When the count runs out, `FLT_HOLD` moves to `FLT_EXTEND` if the low-side supply is still under its release level. If the supply has recovered but the short-circuit flag is still high, the counter reloads. Otherwise the sequencer returns to `FLT_IDLE`. `FLT_EXTEND` leaves once the supply recovers, either to `FLT_IDLE` or, if the short-circuit flag is high at that moment, back to `FLT_HOLD`.

Each gate has a two-state re-arm machine (`GATE_LOCKED`, `GATE_LIVE`). Any block sends it to `GATE_LOCKED`. It returns to `GATE_LIVE` only on a synchronized low-to-high edge of its own command while no block is present. The short-circuit flag and all six commands pass through two-flop synchronizers.

Top module: `inv_gate_guard`

## Requirements
- R1: While reset is applied, all six gates are off and `fault_n` is 1 (released). All four supplies begin in the undervoltage state, so a fault pulse begins in the second cycle after reset is released.
- R2: A gate in the live state follows its command, where 1 means on and 0 means off. The gate changes two clock edges after the command input changes.
- R3: After any block clears, a gate stays off until its own command is seen low and then high. The gate turns on three edges after that rising edge. Each of the six gates re-arms independently of the others.
- R4: A high level on `sc_flag` that lasts one clock makes all three low-side gates off, and drives `fault_n` to 0, three edges later. High-side gates are unaffected.
- R5: A fault pulse lasts at least `FAULT_CYC` cycles, even when its cause disappears sooner. For a one-cycle short-circuit event, `fault_n` is 0 for exactly `FAULT_CYC` cycles.
- R6: A low-side supply code at or below `lo_trip` turns all low-side gates off one edge later. It drives `fault_n` to 0 one edge after that.
- R7: While the low-side supply code has not yet reached `lo_rel`, `fault_n` stays 0 beyond the minimum width. Once the code is at or above `lo_rel` and the minimum width has elapsed, `fault_n` returns to 1 two edges later.
- R8: A supply code strictly between its trip and release thresholds leaves that supply's state unchanged, whether the state is undervoltage or healthy.
- R9: A high-side code for phase p (phase 0 = U, 1 = V, 2 = W, carried in `hi_code[p*8 +: 8]`) at or below `hi_trip` turns off only `gate_hi[p]`, one edge later. It never changes `fault_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | 3 | High-side commands, bit p = phase p |
| cmd_lo | input | 3 | Low-side commands, bit p = phase p |
| sc_flag | input | 1 | Low-side short-circuit comparator output, asynchronous |
| lo_code | input | 8 | Low-side supply code |
| hi_code | input | 24 | High-side supply codes, phase p in bits p*8 +: 8 |
| lo_trip | input | 8 | Low-side trip threshold |
| lo_rel | input | 8 | Low-side release threshold |
| hi_trip | input | 8 | High-side trip threshold |
| hi_rel | input | 8 | High-side release threshold |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| fault_n | output | 1 | Fault line: 0 = pull low, 1 = release |

## Verification
The assertions take several things for granted about the inputs. Each trip threshold must be below its release threshold, because the hysteresis check otherwise has no band to test. The supply codes and thresholds must be synchronous to `clk`, because they feed the watchers without synchronization. `FAULT_CYC` must be at least 2. The stimulus keeps to these conditions: the thresholds are fixed at 100 and 120, and every input is changed only on falling clock edges. Supply codes are moved only to values below, inside and above the hysteresis band.

// File: rtl/gg_pkg.sv
package gg_pkg;
    localparam int PHASES = 3;

    typedef enum logic [1:0] {
        FLT_IDLE,
        FLT_HOLD,
        FLT_EXTEND
    } flt_state_t;

    typedef enum logic {
        SUP_LOW,
        SUP_GOOD
    } sup_state_t;

    typedef enum logic {
        GATE_LOCKED,
        GATE_LIVE
    } gate_state_t;
endpackage

// File: rtl/gg_sync2.sv
module gg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gg_supply_watch.sv
module gg_supply_watch
    import gg_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] trip,
    input  logic [CODE_W-1:0] rel,
    output logic              uv
);
    sup_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SUP_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SUP_LOW:  if (code >= rel)  state_nx = SUP_GOOD;
            SUP_GOOD: if (code <= trip) state_nx = SUP_LOW;
            default:  state_nx = SUP_LOW;
        endcase
    end

    always_comb begin
        uv = (state == SUP_LOW);
    end

    // R8
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((code > trip) && (code < rel)) |=> (uv == $past(uv)));
endmodule

// File: rtl/gg_fault_seq.sv
module gg_fault_seq
    import gg_pkg::*;
#(
    parameter int FAULT_CYC = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sc_hit,
    input  logic ls_uv,
    output logic fault_n,
    output logic lo_block
);
    localparam int CNT_W = (FAULT_CYC > 2) ? $clog2(FAULT_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(FAULT_CYC - 1);

    flt_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLT_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            FLT_IDLE: begin
                if (sc_hit || ls_uv) begin
                    state_nx = FLT_HOLD;
                    cnt_nx   = LOAD;
                end
            end
            FLT_HOLD: begin
                if (cnt != '0)   cnt_nx   = cnt - 1'b1;
                else if (ls_uv)  state_nx = FLT_EXTEND;
                else if (sc_hit) cnt_nx   = LOAD;
                else             state_nx = FLT_IDLE;
            end
            FLT_EXTEND: begin
                if (!ls_uv) begin
                    if (sc_hit) begin
                        state_nx = FLT_HOLD;
                        cnt_nx   = LOAD;
                    end else begin
                        state_nx = FLT_IDLE;
                    end
                end
            end
            default: begin
                state_nx = FLT_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        fault_n  = (state == FLT_IDLE);
        lo_block = (state != FLT_IDLE) || ls_uv;
    end

    // R4
    sc_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_hit |=> !fault_n);

    // R7
    uv_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_uv |=> !fault_n);

    // R7
    release_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> !$past(ls_uv));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);
endmodule

// File: rtl/gg_gate_arm.sv
module gg_gate_arm
    import gg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_s,
    input  logic blk,
    output logic gate_en
);
    gate_state_t state, state_nx;
    logic        cmd_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= GATE_LOCKED;
            cmd_prev <= 1'b0;
        end else begin
            state    <= state_nx;
            cmd_prev <= cmd_s;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_LOCKED: if (!blk && cmd_s && !cmd_prev) state_nx = GATE_LIVE;
            GATE_LIVE:   if (blk) state_nx = GATE_LOCKED;
            default:     state_nx = GATE_LOCKED;
        endcase
    end

    always_comb begin
        gate_en = (state == GATE_LIVE) && cmd_s && !blk;
    end
endmodule

// File: rtl/inv_gate_guard.sv
module inv_gate_guard
    import gg_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int FAULT_CYC = 200000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PHASES-1:0]        cmd_hi,
    input  logic [PHASES-1:0]        cmd_lo,
    input  logic                     sc_flag,
    input  logic [CODE_W-1:0]        lo_code,
    input  logic [PHASES*CODE_W-1:0] hi_code,
    input  logic [CODE_W-1:0]        lo_trip,
    input  logic [CODE_W-1:0]        lo_rel,
    input  logic [CODE_W-1:0]        hi_trip,
    input  logic [CODE_W-1:0]        hi_rel,
    output logic [PHASES-1:0]        gate_hi,
    output logic [PHASES-1:0]        gate_lo,
    output logic                     fault_n
);
    localparam int SYNC_W = 2 * PHASES + 1;

    logic [SYNC_W-1:0] raw_in, syn_out;
    logic [PHASES-1:0] hi_cmd_s, lo_cmd_s, hs_uv;
    logic              sc_s, ls_uv, lo_block;

    assign raw_in = {sc_flag, cmd_lo, cmd_hi};

    gg_sync2 #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_out)
    );

    assign hi_cmd_s = syn_out[PHASES-1:0];
    assign lo_cmd_s = syn_out[2*PHASES-1:PHASES];
    assign sc_s     = syn_out[SYNC_W-1];

    gg_supply_watch #(.CODE_W(CODE_W)) u_lo_sup (
        .clk(clk), .rst_n(rst_n), .code(lo_code),
        .trip(lo_trip), .rel(lo_rel), .uv(ls_uv)
    );

    gg_fault_seq #(.FAULT_CYC(FAULT_CYC)) u_fault (
        .clk(clk), .rst_n(rst_n), .sc_hit(sc_s), .ls_uv(ls_uv),
        .fault_n(fault_n), .lo_block(lo_block)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        gg_supply_watch #(.CODE_W(CODE_W)) u_hi_sup (
            .clk(clk), .rst_n(rst_n), .code(hi_code[p*CODE_W +: CODE_W]),
            .trip(hi_trip), .rel(hi_rel), .uv(hs_uv[p])
        );

        gg_gate_arm u_hi_gate (
            .clk(clk), .rst_n(rst_n), .cmd_s(hi_cmd_s[p]),
            .blk(hs_uv[p]), .gate_en(gate_hi[p])
        );

        gg_gate_arm u_lo_gate (
            .clk(clk), .rst_n(rst_n), .cmd_s(lo_cmd_s[p]),
            .blk(lo_block), .gate_en(gate_lo[p])
        );

        // R9
        hi_uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hs_uv[p] |-> !gate_hi[p]);
    end

    // R6
    lo_off_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_lo != '0) |-> fault_n);
endmodule

// File: tb/sim_inv_gate_guard.sv
module sim_inv_gate_guard;
    localparam int F = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_hi = '0, cmd_lo = '0;
    logic        sc_flag = 1'b0;
    logic [7:0]  lo_code = 8'd200;
    logic [23:0] hi_code = {3{8'd200}};
    logic [7:0]  lo_trip = 8'd100, lo_rel = 8'd120;
    logic [7:0]  hi_trip = 8'd100, hi_rel = 8'd120;
    logic [2:0]  gate_hi, gate_lo;
    logic        fault_n;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] gh;
        logic [2:0] gl;
        logic       fn;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    inv_gate_guard #(.CODE_W(8), .FAULT_CYC(F)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .sc_flag(sc_flag), .lo_code(lo_code), .hi_code(hi_code),
        .lo_trip(lo_trip), .lo_rel(lo_rel), .hi_trip(hi_trip), .hi_rel(hi_rel),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input logic [2:0] gh, input logic [2:0] gl,
                              input logic fn, input string tag);
        exp_t e;
        e.gh = gh; e.gl = gl; e.fn = fn; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: pops expectations queued at this falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_run++;
                if (gate_hi !== e.gh || gate_lo !== e.gl || fault_n !== e.fn) begin
                    n_fail++;
                    $display("FAIL %s: got hi=%b lo=%b fn=%b, expected hi=%b lo=%b fn=%b",
                             e.tag, gate_hi, gate_lo, fault_n, e.gh, e.gl, e.fn);
                end
            end
        end
    end

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected end of sequence");
            finish_run();
        end
    end

    initial begin
        step(2);
        expect_now(3'b000, 3'b000, 1'b1, "R1 in reset");
        step(1);
        rst_n = 1'b1;
        step(2);
        expect_now(3'b000, 3'b000, 1'b0, "R1 start-up fault");
        step(F + 2);
        expect_now(3'b000, 3'b000, 1'b1, "R1 start-up fault ends");

        // first arm of all gates
        cmd_hi = 3'b111; cmd_lo = 3'b111;
        step(2);
        expect_now(3'b000, 3'b000, 1'b1, "R3 not live before edge seen");
        step(1);
        expect_now(3'b111, 3'b111, 1'b1, "R3 armed by rising edge");

        // R2 follow in live state
        cmd_hi = 3'b101;
        step(1);
        expect_now(3'b111, 3'b111, 1'b1, "R2 sync latency");
        step(1);
        expect_now(3'b101, 3'b111, 1'b1, "R2 off follows");
        cmd_hi = 3'b111;
        step(2);
        expect_now(3'b111, 3'b111, 1'b1, "R2 on follows");

        // R4 / R5 short circuit, one cycle
        sc_flag = 1'b1;
        step(1);
        sc_flag = 1'b0;
        step(1);
        expect_now(3'b111, 3'b111, 1'b1, "R4 before trip");
        step(1);
        expect_now(3'b111, 3'b000, 1'b0, "R4 trip");
        step(F - 1);
        expect_now(3'b111, 3'b000, 1'b0, "R5 last pulse cycle");
        step(1);
        expect_now(3'b111, 3'b000, 1'b1, "R5 pulse end, R3 still locked");

        // R3 independent re-arm of low U only
        cmd_lo = 3'b110;
        step(3);
        cmd_lo = 3'b111;
        step(3);
        expect_now(3'b111, 3'b001, 1'b1, "R3 only U re-armed");
        cmd_lo = 3'b001;
        step(3);
        cmd_lo = 3'b111;
        step(3);
        expect_now(3'b111, 3'b111, 1'b1, "R3 V W re-armed");

        // R6 / R7 / R8 long low-side undervoltage
        lo_code = 8'd100;
        step(1);
        expect_now(3'b111, 3'b000, 1'b1, "R6 gates off");
        step(1);
        expect_now(3'b111, 3'b000, 1'b0, "R6 fault");
        step(F + 20);
        expect_now(3'b111, 3'b000, 1'b0, "R7 stretched");
        lo_code = 8'd110;
        step(5);
        expect_now(3'b111, 3'b000, 1'b0, "R8 band keeps undervoltage");
        lo_code = 8'd120;
        step(1);
        expect_now(3'b111, 3'b000, 1'b0, "R7 one edge after release");
        step(1);
        expect_now(3'b111, 3'b000, 1'b1, "R7 released");
        cmd_lo = 3'b000;
        step(3);
        cmd_lo = 3'b111;
        step(3);
        expect_now(3'b111, 3'b111, 1'b1, "R3 re-arm after undervoltage");

        // R8 band while healthy
        lo_code = 8'd110;
        step(5);
        expect_now(3'b111, 3'b111, 1'b1, "R8 band keeps healthy");

        // R5 short undervoltage still gives the full width
        lo_code = 8'd90;
        step(1);
        lo_code = 8'd200;
        expect_now(3'b111, 3'b000, 1'b1, "R6 short dip gates off");
        step(1);
        expect_now(3'b111, 3'b000, 1'b0, "R5 short dip fault");
        step(F - 1);
        expect_now(3'b111, 3'b000, 1'b0, "R5 minimum width held");
        step(1);
        expect_now(3'b111, 3'b000, 1'b1, "R5 minimum width ends");
        cmd_lo = 3'b000;
        step(3);
        cmd_lo = 3'b111;
        step(3);
        expect_now(3'b111, 3'b111, 1'b1, "R3 re-arm after dip");

        // R9 high-side undervoltage on phase V
        hi_code[15:8] = 8'd100;
        step(1);
        expect_now(3'b101, 3'b111, 1'b1, "R9 only V high off");
        step(10);
        expect_now(3'b101, 3'b111, 1'b1, "R9 no fault");
        hi_code[15:8] = 8'd200;
        step(3);
        expect_now(3'b101, 3'b111, 1'b1, "R3 V high locked after recovery");
        cmd_hi = 3'b101;
        step(3);
        cmd_hi = 3'b111;
        step(3);
        expect_now(3'b111, 3'b111, 1'b1, "R9 V high re-armed");

        step(2);
        done = 1;
        finish_run();
    end
endmodule